// File: doc/BRIEF.md
# Decimal-Capable 8-bit Arithmetic and Logic Unit

This block is the arithmetic and logic unit of an accumulator-style processor. Each cycle that `inValid` is high it takes an operation code, two operands, the incoming carry and overflow flags and a decimal-mode enable. One clock edge later it presents the result byte and the negative, overflow, zero and carry flags, with `outValid` high. The operations are add with carry, subtract with borrow, AND, OR, XOR, shift left, logical shift right, rotate left and right through carry, increment, decrement, compare and bit test.

Decimal mode changes only add and subtract. These then treat every nibble as a packed decimal digit. The carry flag reports the corrected decimal carry or borrow. The negative, overflow and zero flags keep describing the plain binary sum, taken before correction. Flags that an operation does not define pass through from the inputs, so the caller can write all four flags back without change. Register storage, operand fetch and instruction decode stay outside the block.

Top module: `bcd_alu`

## Requirements
- R1: Add (`opSel`=0) returns opA + opB + carryIn modulo 256. C is the binary carry out. V is set when opA and opB have the same sign bit and the result's sign bit differs from it.
- R2: Subtract (`opSel`=1) returns opA - opB - (1 - carryIn) modulo 256. C=1 means no borrow occurred. V is set when opA and opB have different sign bits and the result's sign bit differs from opA.
- R3: With decimalEn=1, add works digit by digit, starting at the low nibble. Each digit sum is the two nibbles plus the incoming digit carry. A digit sum above 9 has 6 added, keeps its low 4 bits and carries 1 into the next digit. C is the carry out of the top digit. A nibble above 9 on an input goes through the same rule with no range check. decimalEn has no effect on any operation other than add and subtract.
- R4: With decimalEn=1, subtract works digit by digit, starting at the low nibble. Each digit difference is the two nibbles minus the incoming digit borrow, where the first borrow is 1 - carryIn. A negative digit difference has 6 subtracted, keeps its low 4 bits and borrows 1 from the next digit. C is 1 exactly when the top digit does not borrow.
- R5: In decimal mode, N, V and Z for add and subtract are those of the uncorrected binary result of R1 or R2.
- R6: AND (2), OR (3) and XOR (4) combine opA with opB bitwise. N is result bit 7 and Z is set when the result is zero. C and V equal carryIn and overflowIn.
- R7: Shift left (5) moves opA up one bit, puts 0 in bit 0 and sends opA bit 7 to C. Logical shift right (6) moves opA down one bit, puts 0 in bit 7 (so N=0) and sends opA bit 0 to C. V passes through for both.
- R8: Rotate left (7) puts carryIn into bit 0 and sends opA bit 7 to C. Rotate right (8) puts carryIn into bit 7 and sends opA bit 0 to C. N and Z come from the result and V passes through.
- R9: Increment (9) and decrement (10) act on opA modulo 256. N and Z come from the result, and C and V pass through.
- R10: Compare (11) computes opA - opB without borrow. N and Z come from that difference, and C=1 when opA >= opB unsigned. The result port returns opA unchanged and V passes through.
- R11: Bit test (12) returns opA unchanged. N is opB bit 7, V is opB bit 6, Z is set when (opA AND opB) is zero, and C passes through.
- R12: Op codes 13 to 15 return opA. N and Z come from opA, and C and V pass through.
- R13: The outputs are registered. `outValid` is `inValid` delayed by one clock. While `inValid` is low the result and flags hold their values. Reset (active-low `rstN`) clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation request for this cycle |
| opSel | input | 4 | Operation code (see requirements) |
| opA | input | 8 | Accumulator-side operand |
| opB | input | 8 | Memory-side operand |
| carryIn | input | 1 | Incoming carry flag |
| overflowIn | input | 1 | Incoming overflow flag, passed through where unchanged |
| decimalEn | input | 1 | Decimal mode for add and subtract |
| outValid | output | 1 | Result and flags updated this cycle |
| result | output | 8 | Result byte |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |

## Verification
The bench targets decimal sums that wrap, such as 99 + 01. The result there is 00 with C set while Z stays clear, so a design that took Z from the corrected value would report zero. It targets decimal borrows across both digits (00 - 01 giving 99 with C clear) and nibbles above 9, where a range-checked or skipped adjust would give a different byte. It also targets shift-right and rotate-right with bit 0 set, where a swapped carry source would show, and logic operations with decimal mode on, which a leaking decimal gate would corrupt. Long random runs also cover compare and bit test, whose result must stay equal to opA, and idle cycles, where any change on the outputs would be visible.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } aluOpT;

  // Strobes from the decoder to the datapath; at most one operation bit set.
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doCmp;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doShl;
    logic doShr;
    logic doRotL;
    logic doRotR;
    logic doInc;
    logic doDec;
    logic doBit;
    logic bcdMode;
  } aluStrobeT;

endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            decimalEn,
  output aluStrobeT       strobe
);

  always_comb begin
    strobe = '0;
    unique case (opSel)
      OP_ADC:  strobe.doAdd  = 1'b1;
      OP_SBC:  strobe.doSub  = 1'b1;
      OP_AND:  strobe.doAnd  = 1'b1;
      OP_OR:   strobe.doOr   = 1'b1;
      OP_XOR:  strobe.doXor  = 1'b1;
      OP_SHL:  strobe.doShl  = 1'b1;
      OP_SHR:  strobe.doShr  = 1'b1;
      OP_ROL:  strobe.doRotL = 1'b1;
      OP_ROR:  strobe.doRotR = 1'b1;
      OP_INC:  strobe.doInc  = 1'b1;
      OP_DEC:  strobe.doDec  = 1'b1;
      OP_CMP:  strobe.doCmp  = 1'b1;
      OP_BIT:  strobe.doBit  = 1'b1;
      default: strobe = '0; // reserved codes fall back to pass-through (R12)
    endcase
    // Decimal correction is gated to the two arithmetic operations only (R3)
    strobe.bcdMode = decimalEn & (strobe.doAdd | strobe.doSub);
  end

endmodule

// File: rtl/bcd_alu_datapath.sv
module bcd_alu_datapath
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  aluStrobeT         strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              overflowIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC
);

  localparam int DIGITS = DATA_W / 4;
  localparam int MSB    = DATA_W - 1;

  // ---------------- shared binary adder (add, subtract, compare) ----------
  logic              invertB;
  logic              adderCin;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   binSum;
  logic              binCarry;
  logic              binOvf;

  assign invertB  = strobe.doSub | strobe.doCmp;
  assign adderCin = strobe.doCmp ? 1'b1 : carryIn;
  assign bEff     = invertB ? ~opB : opB;
  assign binSum   = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, adderCin};
  assign binCarry = binSum[DATA_W];
  assign binOvf   = (opA[MSB] == bEff[MSB]) && (binSum[MSB] != opA[MSB]);

  // ---------------- per-digit decimal correction, both carry cases -------
  logic [DIGITS-1:0][3:0] addDigC0, addDigC1;
  logic [DIGITS-1:0]      addCoC0,  addCoC1;
  logic [DIGITS-1:0][3:0] subDigB0, subDigB1;
  logic [DIGITS-1:0]      subBoB0,  subBoB1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] nibA, nibB;
    logic [4:0] rawSum0, rawSum1, rawDiff0, rawDiff1;

    assign nibA     = opA[g*4 +: 4];
    assign nibB     = opB[g*4 +: 4];
    assign rawSum0  = {1'b0, nibA} + {1'b0, nibB};
    assign rawSum1  = rawSum0 + 5'd1;
    assign rawDiff0 = {1'b0, nibA} - {1'b0, nibB};
    assign rawDiff1 = rawDiff0 - 5'd1;

    // Digit above 9: add 6 and carry, with no check on input range (R3)
    assign addCoC0[g]  = rawSum0 > 5'd9;
    assign addCoC1[g]  = rawSum1 > 5'd9;
    assign addDigC0[g] = rawSum0[3:0] + (addCoC0[g] ? 4'd6 : 4'd0);
    assign addDigC1[g] = rawSum1[3:0] + (addCoC1[g] ? 4'd6 : 4'd0);

    // Negative digit: subtract 6 and borrow (R4)
    assign subBoB0[g]  = rawDiff0[4];
    assign subBoB1[g]  = rawDiff1[4];
    assign subDigB0[g] = rawDiff0[3:0] - (subBoB0[g] ? 4'd6 : 4'd0);
    assign subDigB1[g] = rawDiff1[3:0] - (subBoB1[g] ? 4'd6 : 4'd0);
  end

  // Digit chain: select the precomputed candidate by the incoming carry
  logic [DATA_W-1:0] bcdSum, bcdDiff;
  logic              bcdAddCarry, bcdSubCarry;
  logic              addChain, subChain;

  always_comb begin
    addChain = carryIn;
    subChain = ~carryIn;
    bcdSum   = '0;
    bcdDiff  = '0;
    for (int i = 0; i < DIGITS; i++) begin
      bcdSum[i*4 +: 4]  = addChain ? addDigC1[i] : addDigC0[i];
      addChain          = addChain ? addCoC1[i]  : addCoC0[i];
      bcdDiff[i*4 +: 4] = subChain ? subDigB1[i] : subDigB0[i];
      subChain          = subChain ? subBoB1[i]  : subBoB0[i];
    end
    bcdAddCarry = addChain;
    bcdSubCarry = ~subChain;
  end

  // ---------------- shifter ----------------------------------------------
  logic [DATA_W-1:0] shlVal, shrVal, rolVal, rorVal;
  assign shlVal = {opA[MSB-1:0], 1'b0};
  assign shrVal = {1'b0, opA[MSB:1]};
  assign rolVal = {opA[MSB-1:0], carryIn};
  assign rorVal = {carryIn, opA[MSB:1]};

  // ---------------- result and flag selection -----------------------------
  logic [DATA_W-1:0] nxtRes;
  logic [DATA_W-1:0] nzSrc;
  logic              nxtN, nxtV, nxtZ, nxtC;
  logic              nzFromSrc;

  always_comb begin
    nxtRes    = opA;
    nzSrc     = opA;
    nzFromSrc = 1'b1;
    nxtC      = carryIn;
    nxtV      = overflowIn;
    nxtN      = 1'b0;
    nxtZ      = 1'b0;
    if (strobe.doAdd) begin
      nxtRes = strobe.bcdMode ? bcdSum : binSum[MSB:0];
      nzSrc  = binSum[MSB:0];
      nxtV   = binOvf;
      nxtC   = strobe.bcdMode ? bcdAddCarry : binCarry;
    end else if (strobe.doSub) begin
      nxtRes = strobe.bcdMode ? bcdDiff : binSum[MSB:0];
      nzSrc  = binSum[MSB:0];
      nxtV   = binOvf;
      nxtC   = strobe.bcdMode ? bcdSubCarry : binCarry;
    end else if (strobe.doCmp) begin
      nzSrc  = binSum[MSB:0];
      nxtC   = binCarry;
    end else if (strobe.doAnd) begin
      nxtRes = opA & opB;
      nzSrc  = nxtRes;
    end else if (strobe.doOr) begin
      nxtRes = opA | opB;
      nzSrc  = nxtRes;
    end else if (strobe.doXor) begin
      nxtRes = opA ^ opB;
      nzSrc  = nxtRes;
    end else if (strobe.doShl) begin
      nxtRes = shlVal;
      nzSrc  = shlVal;
      nxtC   = opA[MSB];
    end else if (strobe.doShr) begin
      nxtRes = shrVal;
      nzSrc  = shrVal;
      nxtC   = opA[0];
    end else if (strobe.doRotL) begin
      nxtRes = rolVal;
      nzSrc  = rolVal;
      nxtC   = opA[MSB];
    end else if (strobe.doRotR) begin
      nxtRes = rorVal;
      nzSrc  = rorVal;
      nxtC   = opA[0];
    end else if (strobe.doInc) begin
      nxtRes = opA + {{(DATA_W-1){1'b0}}, 1'b1};
      nzSrc  = nxtRes;
    end else if (strobe.doDec) begin
      nxtRes = opA - {{(DATA_W-1){1'b0}}, 1'b1};
      nzSrc  = nxtRes;
    end else if (strobe.doBit) begin
      nzFromSrc = 1'b0;
      nxtN      = opB[MSB];
      nxtV      = opB[MSB-1];
      nxtZ      = (opA & opB) == '0;
    end
    if (nzFromSrc) begin
      nxtN = nzSrc[MSB];
      nxtZ = nzSrc == '0;
    end
  end

  // ---------------- output register ---------------------------------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagV    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result <= nxtRes;
        flagN  <= nxtN;
        flagV  <= nxtV;
        flagZ  <= nxtZ;
        flagC  <= nxtC;
      end
    end
  end

  // ---------------- assertions --------------------------------------------
  p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(flagC)));

  p_shr_clears_n_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.doShr) |=> (!flagN && flagC == $past(opA[0])));

  p_logic_keeps_cv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (strobe.doAnd || strobe.doOr || strobe.doXor))
      |=> (flagC == $past(carryIn) && flagV == $past(overflowIn)));

  p_incdec_keeps_cv_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (strobe.doInc || strobe.doDec))
      |=> (flagC == $past(carryIn) && flagV == $past(overflowIn)));

  p_cmp_keeps_a_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.doCmp) |=> (result == $past(opA)));

  p_bit_flags_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.doBit)
      |=> (flagN == $past(opB[MSB]) && flagV == $past(opB[MSB-1]) && result == $past(opA)));

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic              decimalEn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC
);

  aluStrobeT strobe;

  bcd_alu_ctrl i_ctrl (
    .opSel     (opSel),
    .decimalEn (decimalEn),
    .strobe    (strobe)
  );

  bcd_alu_datapath #(
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .outValid   (outValid),
    .result     (result),
    .flagN      (flagN),
    .flagV      (flagV),
    .flagZ      (flagZ),
    .flagC      (flagC)
  );

  // Decimal mode must not alter a registered logic result (R3)
  p_bcd_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && decimalEn && opSel == 4'd2) |=> (result == $past(opA & opB)));

endmodule

// File: tb/test_bcd_alu.sv
module test_bcd_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [3:0] opSel;
  logic [7:0] opA, opB;
  logic       carryIn, overflowIn, decimalEn;
  logic       outValid;
  logic [7:0] result;
  logic       flagN, flagV, flagZ, flagC;

  int checkCount = 0;
  int failCount  = 0;
  logic [11:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alu i_bcd_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .carryIn(carryIn), .overflowIn(overflowIn),
    .decimalEn(decimalEn), .outValid(outValid), .result(result),
    .flagN(flagN), .flagV(flagV), .flagZ(flagZ), .flagC(flagC)
  );

  // Behavioural reference: returns {result, N, V, Z, C}
  function automatic logic [11:0] refModel(int op, int a, int b, int c, int ov, int dec);
    int r, nz, cf, vf, n, z, s, lo, hi, br;
    r = a; nz = a; cf = c; vf = ov; n = -1; z = -1;
    case (op)
      0: begin
        s = a + b + c; r = s & 255; nz = r; cf = (s > 255);
        vf = (((a ^ r) & (b ^ r) & 128) != 0);
        if (dec != 0) begin
          lo = (a & 15) + (b & 15) + c;
          if (lo > 9) lo = lo + 6;
          hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
          if (hi > 9) hi = hi + 6;
          cf = (hi > 15);
          r = ((hi & 15) << 4) | (lo & 15);
        end
      end
      1: begin
        s = a - b - (1 - c); nz = s & 255; r = nz; cf = (s >= 0);
        vf = (((a ^ b) & (a ^ nz) & 128) != 0);
        if (dec != 0) begin
          lo = (a & 15) - (b & 15) - (1 - c); br = 0;
          if (lo < 0) begin lo = lo - 6; br = 1; end
          hi = (a >> 4) - (b >> 4) - br;
          if (hi < 0) begin hi = hi - 6; cf = 0; end else cf = 1;
          r = ((hi & 15) << 4) | (lo & 15);
        end
      end
      2: begin r = a & b; nz = r; end
      3: begin r = a | b; nz = r; end
      4: begin r = a ^ b; nz = r; end
      5: begin r = (a << 1) & 255; nz = r; cf = a >> 7; end
      6: begin r = a >> 1; nz = r; cf = a & 1; end
      7: begin r = ((a << 1) | c) & 255; nz = r; cf = a >> 7; end
      8: begin r = (a >> 1) | (c << 7); nz = r; cf = a & 1; end
      9: begin r = (a + 1) & 255; nz = r; end
      10: begin r = (a + 255) & 255; nz = r; end
      11: begin s = a - b; nz = s & 255; cf = (s >= 0); r = a; end
      12: begin r = a; n = (b >> 7) & 1; vf = (b >> 6) & 1; z = ((a & b) == 0); end
      default: begin r = a; nz = a; end
    endcase
    if (n < 0) begin n = (nz >> 7) & 1; z = (nz == 0); end
    refModel = {r[7:0], n[0], vf[0], z[0], cf[0]};
  endfunction

  function automatic string reqTag(int op, int dec);
    case (op)
      0: reqTag = (dec != 0) ? "R3,R5" : "R1";
      1: reqTag = (dec != 0) ? "R4,R5" : "R2";
      2, 3, 4: reqTag = "R6";
      5, 6: reqTag = "R7";
      7, 8: reqTag = "R8";
      9, 10: reqTag = "R9";
      11: reqTag = "R10";
      12: reqTag = "R11";
      default: reqTag = "R12";
    endcase
  endfunction

  task automatic checkVal(string req, logic [11:0] act, logic [11:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, sample at the next one.
  task automatic step(bit v, int op, int a, int b, int c, int ov, int dec);
    logic [11:0] exp;
    string tag;
    inValid = v; opSel = op[3:0]; opA = a[7:0]; opB = b[7:0];
    carryIn = c[0]; overflowIn = ov[0]; decimalEn = dec[0];
    if (v) begin
      exp = refModel(op, a, b, c, ov, dec);
      lastExp = exp;
      tag = reqTag(op, dec);
    end else begin
      exp = lastExp;
      tag = "R13 hold";
    end
    @(negedge clk);
    checkVal("R13 valid", {11'd0, outValid}, {11'd0, v});
    checkVal(tag, {result, flagN, flagV, flagZ, flagC}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checkCount++;
    failCount++;
    $display("FAIL R13 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 0; opSel = 0; opA = 0; opB = 0;
    carryIn = 0; overflowIn = 0; decimalEn = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    checkVal("R13 reset", {result, flagN, flagV, flagZ, flagC, outValid},
             {8'h00, 5'b00000});
    rstN = 1'b1;

    // R1 binary add
    step(1, 0, 8'h50, 8'h50, 0, 0, 0);   // signed overflow
    step(1, 0, 8'hFF, 8'h01, 0, 0, 0);   // carry out, zero
    step(1, 0, 8'h10, 8'h20, 1, 1, 0);   // carry in used, V cleared
    // R2 binary subtract
    step(1, 1, 8'h50, 8'hB0, 1, 0, 0);   // overflow
    step(1, 1, 8'h00, 8'h01, 1, 0, 0);   // borrow
    step(1, 1, 8'h05, 8'h05, 0, 0, 0);   // borrow pending in
    // R3 decimal add and R5 binary flags
    step(1, 0, 8'h99, 8'h01, 0, 0, 1);   // 00 with C, Z clear
    step(1, 0, 8'h58, 8'h46, 1, 0, 1);   // 05 with C
    step(1, 0, 8'h0F, 8'h00, 0, 0, 1);   // invalid nibble adjusted
    step(1, 0, 8'hFA, 8'hFB, 1, 0, 1);   // both nibbles invalid
    // R4 decimal subtract
    step(1, 1, 8'h00, 8'h01, 1, 0, 1);   // 99 with borrow
    step(1, 1, 8'h46, 8'h12, 1, 0, 1);
    step(1, 1, 8'h40, 8'h13, 0, 0, 1);
    // R6 logic, with decimal on
    step(1, 2, 8'hF0, 8'h3C, 1, 1, 1);
    step(1, 3, 8'h00, 8'h00, 0, 1, 0);
    step(1, 4, 8'hAA, 8'h55, 1, 0, 1);
    // R7 shifts
    step(1, 6, 8'h81, 8'h00, 0, 1, 0);
    step(1, 5, 8'h80, 8'h00, 0, 0, 0);
    // R8 rotates
    step(1, 7, 8'h80, 8'h00, 1, 0, 0);
    step(1, 8, 8'h01, 8'h00, 1, 0, 0);
    step(1, 8, 8'h01, 8'h00, 0, 0, 0);
    // R9 increment and decrement wrap
    step(1, 9, 8'hFF, 8'h00, 1, 1, 0);
    step(1, 10, 8'h00, 8'h00, 0, 0, 0);
    // R10 compare
    step(1, 11, 8'h40, 8'h40, 0, 1, 1);
    step(1, 11, 8'h10, 8'h20, 1, 0, 0);
    // R11 bit test
    step(1, 12, 8'h0F, 8'hC0, 1, 0, 0);
    step(1, 12, 8'h01, 8'h41, 0, 1, 0);
    // R12 reserved codes
    step(1, 13, 8'h80, 8'hFF, 1, 1, 1);
    step(1, 15, 8'h00, 8'h12, 0, 0, 0);
    // R13 hold while idle, with inputs moving
    step(0, 1, 8'h33, 8'h77, 1, 1, 1);
    step(0, 6, 8'hFF, 8'h01, 0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 256,
           $urandom % 256, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule